// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block is the per-processor end of a two-level interrupt controller. It keeps the processor's current priority, one pending slot (a source number and the priority it arrived with) and an inter-processor interrupt request priority. A source controller offers interrupts over a valid/ready stream. The block either takes the offer, which may displace a less favoured pending interrupt, or refuses it. A single level output tells the core that something is pending. Refused, displaced and revoked sources are handed back on a reject pulse so the source controller can retry them later. End-of-interrupt and resend requests go out on their own pulses.

Software drives single-cycle commands: accept, end-of-interrupt, set current priority, set IPI request and poll. Accept and poll return a response one cycle later. Priorities are numerically ordered, so a lower value is more favoured, and the all-ones value means "none" or "fully masked". The inter-processor interrupt uses the same pending slot as external interrupts, under the reserved source number 2 (parameter `IPI_SRC`).

Offer stream rules: `offer_ready` is low in any cycle with `cmd_valid` high, so a command always wins over an offer. An offer transfers when `offer_valid && offer_ready`. The outbound pulses `rej_valid`, `eoi_valid` and `resend_req` are not back-pressured, so the source side must take them in the cycle they appear.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the status word (priority in bits 31:24, source in bits 23:0) is zero, the pending priority is 0xFF, the IPI request is 0xFF and `irq_out` is low.
- R2: An offer is refused when its priority is >= the current priority, or when a source is pending at a priority <= the offered one. A refusal pulses `rej_valid` with the offered source one cycle after the transfer, and the state is left unchanged.
- R3: A taken offer loads its source and priority and sets `irq_out`. If a non-IPI source was pending, that source is pulsed on the reject output.
- R4: Command code 0 (accept) returns the status word on `rsp_word` one cycle later. It then copies the pending priority into the current priority, clears the source field, sets the pending priority to 0xFF and lowers `irq_out`.
- R5: Command code 3 (set IPI request, value in bits 7:0) stores the request. If the request is below the current priority, an IPI check runs. The check does nothing when a source is pending at a priority <= the request. Otherwise it rejects any non-IPI pending source, loads source 2 at the request priority and raises `irq_out`.
- R6: Command code 2 (set current priority, value in bits 7:0) with a value below the old one revokes a pending interrupt whose priority is >= the new value. Revoking clears the source, sets the pending priority to 0xFF, lowers `irq_out` and rejects a non-IPI source.
- R7: Command code 2 with a value >= the old current priority pulses `resend_req`. It then runs the IPI check of R5 if the IPI request is below the new current priority.
- R8: Command code 1 (end-of-interrupt) sets the current priority from bits 31:24 of the data word. It pulses `eoi_valid` with bits 23:0, unless those bits are 0 or 2. It then pulses `resend_req` and runs the IPI check of R5 if the IPI request is below the new current priority.
- R9: Command code 4 (poll) returns the status word and the IPI request, and changes no state.
- R10: While `cmd_valid` is high, `offer_ready` is low and the offer has no effect.
- R11: `irq_out` is high exactly when the pending source field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 accept, 1 EOI, 2 set priority, 3 set IPI request, 4 poll |
| cmd_data | input | 32 | Command data word |
| offer_valid | input | 1 | Offer stream valid |
| offer_ready | output | 1 | Offer stream ready |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| rej_valid | output | 1 | Reject pulse to the source side |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source side |
| eoi_src | output | 24 | Source number being retired |
| resend_req | output | 1 | Request that source controllers re-offer held interrupts |
| rsp_valid | output | 1 | Response valid for accept or poll |
| rsp_word | output | 32 | Returned status word |
| rsp_req | output | 8 | Returned IPI request priority |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
On every cycle, the assertions check that the line level follows the pending slot and that a command stalls the offer stream. They also check that poll holds all state, that accept lowers the line, that a refused offer comes back as a reject, and that a tightened priority revokes or a favoured IPI request raises the line. The order of effects inside one command cannot be seen from a single-cycle property. That order covers a displaced source being rejected before the IPI is loaded, and the IPI re-check following an EOI or a relaxed priority. Only the bench's sweeps show it, by comparing every response, pulse and status word against a reference model across a grid of current, offered and requested priorities.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT  = 3'd0,
    OP_EOI     = 3'd1,
    OP_SET_PRI = 3'd2,
    OP_SET_IPI = 3'd3,
    OP_POLL    = 3'd4
  } icp_op_e;
endpackage

// File: rtl/icp_offer_judge.sv
module icp_offer_judge #(
  parameter int PRI_W = 8
) (
  input  logic [PRI_W-1:0] cur_pri,
  input  logic             has_pend,
  input  logic [PRI_W-1:0] pend_pri,
  input  logic [PRI_W-1:0] new_pri,
  output logic             take
);
  // Refused when not more favoured than current priority, or not strictly
  // more favoured than what already sits in the slot.
  always_comb begin
    take = (new_pri < cur_pri) && !(has_pend && (pend_pri <= new_pri));
  end
endmodule

// File: rtl/icp_ipi_judge.sv
module icp_ipi_judge #(
  parameter int PRI_W = 8
) (
  input  logic             enable,
  input  logic             has_pend,
  input  logic [PRI_W-1:0] pend_pri,
  input  logic [PRI_W-1:0] req_pri,
  output logic             take
);
  always_comb begin
    take = enable && !(has_pend && (pend_pri <= req_pri));
  end
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import icp_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRI_W   = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [PRI_W+SRC_W-1:0] cmd_data,
  input  logic                   offer_valid,
  output logic                   offer_ready,
  input  logic [SRC_W-1:0]       offer_src,
  input  logic [PRI_W-1:0]       offer_pri,
  output logic                   rej_valid,
  output logic [SRC_W-1:0]       rej_src,
  output logic                   eoi_valid,
  output logic [SRC_W-1:0]       eoi_src,
  output logic                   resend_req,
  output logic                   rsp_valid,
  output logic [PRI_W+SRC_W-1:0] rsp_word,
  output logic [PRI_W-1:0]       rsp_req,
  output logic                   irq_out
);
  localparam int WORD_W = PRI_W + SRC_W;
  localparam logic [PRI_W-1:0] PRI_NONE = {PRI_W{1'b1}};
  localparam logic [SRC_W-1:0] SRC_IPI  = SRC_W'(IPI_SRC);

  icp_op_e op;
  assign op = icp_op_e'(cmd_op);

  // Architectural state
  logic [PRI_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0] xisr_q;
  logic             irq_q;

  assign offer_ready = !cmd_valid;
  wire offer_fire = offer_valid && offer_ready;

  // Stage 1: primary effect of the command or offer
  logic [PRI_W-1:0] s1_cppr, s1_pend, s1_mfrr;
  logic [SRC_W-1:0] s1_xisr;
  logic             s1_irq, s1_rej, s1_eoi, s1_resend, s1_rsp;
  logic [SRC_W-1:0] s1_rej_src, s1_eoi_src;
  logic             chk_en;
  logic             offer_take;
  logic [PRI_W-1:0] set_val;

  assign set_val = cmd_data[PRI_W-1:0];

  icp_offer_judge #(.PRI_W(PRI_W)) u_offer (
    .cur_pri  (cppr_q),
    .has_pend (xisr_q != '0),
    .pend_pri (pend_q),
    .new_pri  (offer_pri),
    .take     (offer_take)
  );

  always_comb begin
    s1_cppr    = cppr_q;
    s1_pend    = pend_q;
    s1_mfrr    = mfrr_q;
    s1_xisr    = xisr_q;
    s1_irq     = irq_q;
    s1_rej     = 1'b0;
    s1_rej_src = '0;
    s1_eoi     = 1'b0;
    s1_eoi_src = '0;
    s1_resend  = 1'b0;
    s1_rsp     = 1'b0;
    chk_en     = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_ACCEPT: begin
          s1_rsp  = 1'b1;
          s1_cppr = pend_q;
          s1_xisr = '0;
          s1_pend = PRI_NONE;
          s1_irq  = 1'b0;
        end
        OP_EOI: begin
          s1_cppr    = cmd_data[WORD_W-1:SRC_W];
          s1_eoi_src = cmd_data[SRC_W-1:0];
          s1_eoi     = (s1_eoi_src != '0) && (s1_eoi_src != SRC_IPI);
          s1_resend  = 1'b1;
          chk_en     = mfrr_q < s1_cppr;
        end
        OP_SET_PRI: begin
          s1_cppr = set_val;
          if (set_val < cppr_q) begin
            if ((xisr_q != '0) && (set_val <= pend_q)) begin
              s1_rej     = (xisr_q != SRC_IPI);
              s1_rej_src = xisr_q;
              s1_xisr    = '0;
              s1_pend    = PRI_NONE;
              s1_irq     = 1'b0;
            end
          end else begin
            s1_resend = 1'b1;
            chk_en    = mfrr_q < set_val;
          end
        end
        OP_SET_IPI: begin
          s1_mfrr = set_val;
          chk_en  = set_val < cppr_q;
        end
        OP_POLL: s1_rsp = 1'b1;
        default: ;
      endcase
    end else if (offer_fire) begin
      if (!offer_take) begin
        s1_rej     = 1'b1;
        s1_rej_src = offer_src;
      end else begin
        s1_rej     = (xisr_q != '0) && (xisr_q != SRC_IPI);
        s1_rej_src = xisr_q;
        s1_xisr    = offer_src;
        s1_pend    = offer_pri;
        s1_irq     = 1'b1;
      end
    end
  end

  // Stage 2: IPI check on the post-command state
  logic ipi_take;
  icp_ipi_judge #(.PRI_W(PRI_W)) u_ipi (
    .enable   (chk_en),
    .has_pend (s1_xisr != '0),
    .pend_pri (s1_pend),
    .req_pri  (s1_mfrr),
    .take     (ipi_take)
  );

  logic [PRI_W-1:0] n_pend;
  logic [SRC_W-1:0] n_xisr, n_rej_src;
  logic             n_irq, n_rej;

  always_comb begin
    n_pend    = s1_pend;
    n_xisr    = s1_xisr;
    n_irq     = s1_irq;
    n_rej     = s1_rej;
    n_rej_src = s1_rej_src;
    if (ipi_take) begin
      if ((s1_xisr != '0) && (s1_xisr != SRC_IPI)) begin
        n_rej     = 1'b1;
        n_rej_src = s1_xisr;
      end
      n_xisr = SRC_IPI;
      n_pend = s1_mfrr;
      n_irq  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q     <= '0;
      xisr_q     <= '0;
      pend_q     <= PRI_NONE;
      mfrr_q     <= PRI_NONE;
      irq_q      <= 1'b0;
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      resend_req <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
      rsp_req    <= '0;
    end else begin
      cppr_q     <= s1_cppr;
      xisr_q     <= n_xisr;
      pend_q     <= n_pend;
      mfrr_q     <= s1_mfrr;
      irq_q      <= n_irq;
      rej_valid  <= n_rej;
      rej_src    <= n_rej ? n_rej_src : '0;
      eoi_valid  <= s1_eoi;
      eoi_src    <= s1_eoi ? s1_eoi_src : '0;
      resend_req <= s1_resend;
      rsp_valid  <= s1_rsp;
      rsp_word   <= s1_rsp ? {cppr_q, xisr_q} : '0;
      rsp_req    <= s1_rsp ? mfrr_q : '0;
    end
  end

  assign irq_out = irq_q;

  // Assertions
  AST_LINE_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xisr_q != '0)); // R11
  AST_EMPTY_SLOT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr_q == '0) |-> (pend_q == PRI_NONE)); // R4
  AST_CMD_STALLS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !offer_ready); // R10
  AST_ACCEPT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> (!irq_out && rsp_valid)); // R4
  AST_POLL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> ($stable(cppr_q) && $stable(xisr_q) &&
      $stable(pend_q) && $stable(mfrr_q) && rsp_valid)); // R9
  AST_REFUSED_OFFER_BOUNCES: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && offer_ready && offer_pri >= cppr_q) |=>
      (rej_valid && rej_src == $past(offer_src) && $stable(xisr_q))); // R2
  AST_IPI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && set_val < cppr_q && xisr_q == '0) |=>
      (irq_out && xisr_q == SRC_IPI)); // R5
  AST_REVOKE_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && set_val < cppr_q && xisr_q != '0 &&
     set_val <= pend_q) |=> !irq_out); // R6
endmodule

// File: tb/cpu_irq_presenter_test.sv
module cpu_irq_presenter_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_pri = '0;
  logic        rej_valid, eoi_valid, resend_req, rsp_valid, irq_out;
  logic [23:0] rej_src, eoi_src;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_req;

  always #(CLK_P/2) clk = ~clk;

  cpu_irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_src(offer_src), .offer_pri(offer_pri), .rej_valid(rej_valid),
    .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_req(resend_req), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .rsp_req(rsp_req), .irq_out(irq_out)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model state
  logic [7:0]  m_cppr, m_pend, m_mfrr;
  logic [23:0] m_xisr;
  logic [31:0] last_word;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(input int j);
    return (j == 7) ? 8'hFF : 8'(j * 34);
  endfunction

  task automatic apply(input bit cv, input logic [2:0] op, input logic [31:0] d,
                       input bit ov, input logic [23:0] os, input logic [7:0] opr);
    bit e_rej = 0, e_eoi = 0, e_res = 0, e_rsp = 0, tr = 0;
    logic [23:0] e_rs = '0, e_es = '0;
    logic [31:0] e_word = '0;
    logic [7:0]  e_req = '0, tp = '0, v;
    string tag;
    tag = "R2";
    if (cv) begin
      case (op)
        3'd0: begin tag = "R4"; e_rsp = 1; e_word = {m_cppr, m_xisr}; e_req = m_mfrr;
          m_cppr = m_pend; m_xisr = '0; m_pend = 8'hFF; end
        3'd1: begin tag = "R8"; m_cppr = d[31:24];
          if (d[23:0] != 0 && d[23:0] != 2) begin e_eoi = 1; e_es = d[23:0]; end
          e_res = 1; tr = m_mfrr < m_cppr; tp = m_mfrr; end
        3'd2: begin v = d[7:0];
          if (v < m_cppr) begin tag = "R6";
            if (m_xisr != 0 && v <= m_pend) begin
              if (m_xisr != 2) begin e_rej = 1; e_rs = m_xisr; end
              m_xisr = '0; m_pend = 8'hFF;
            end
          end else begin tag = "R7"; e_res = 1; tr = m_mfrr < v; tp = m_mfrr; end
          m_cppr = v; end
        3'd3: begin tag = "R5"; m_mfrr = d[7:0]; tr = m_mfrr < m_cppr; tp = m_mfrr; end
        default: begin tag = "R9"; e_rsp = 1; e_word = {m_cppr, m_xisr}; e_req = m_mfrr; end
      endcase
      if (ov) tag = {tag, "/R10"};
    end else if (ov) begin
      if (opr >= m_cppr || (m_xisr != 0 && m_pend <= opr)) begin
        e_rej = 1; e_rs = os;
      end else begin tag = "R3";
        if (m_xisr != 0 && m_xisr != 2) begin e_rej = 1; e_rs = m_xisr; end
        m_xisr = os; m_pend = opr;
      end
    end
    if (tr && !(m_xisr != 0 && m_pend <= tp)) begin
      if (m_xisr != 0 && m_xisr != 2) begin e_rej = 1; e_rs = m_xisr; end
      m_xisr = 24'd2; m_pend = tp;
    end
    if (e_rsp) last_word = e_word;
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    offer_valid = ov; offer_src = os; offer_pri = opr;
    #1;
    chk("R10", "offer_ready", 32'(offer_ready), 32'(!cv));
    @(posedge clk);
    @(negedge clk);
    vectors++;
    chk(tag, "rej_valid", 32'(rej_valid), 32'(e_rej));
    if (e_rej) chk(tag, "rej_src", 32'(rej_src), 32'(e_rs));
    chk(tag, "eoi_valid", 32'(eoi_valid), 32'(e_eoi));
    if (e_eoi) chk(tag, "eoi_src", 32'(eoi_src), 32'(e_es));
    chk(tag, "resend_req", 32'(resend_req), 32'(e_res));
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e_rsp));
    if (e_rsp) begin
      chk(tag, "rsp_word", rsp_word, e_word);
      chk(tag, "rsp_req", 32'(rsp_req), 32'(e_req));
    end
    chk("R11", "irq_out", 32'(irq_out), 32'(m_xisr != 0));
    cmd_valid = 0; offer_valid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_cppr = 0; m_xisr = 0; m_pend = 8'hFF; m_mfrr = 8'hFF; last_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state seen through poll, then accept exposing pending priority 0xFF
    chk("R1", "irq_out after reset", 32'(irq_out), 32'd0);
    apply(1, 3'd4, 0, 0, 0, 0);
    chk("R1", "poll word after reset", rsp_word, 32'h0);
    chk("R1", "poll request after reset", 32'(rsp_req), 32'hFF);
    apply(1, 3'd0, 0, 0, 0, 0);
    apply(1, 3'd4, 0, 0, 0, 0);
    chk("R1", "current priority after accept from reset", 32'(rsp_word[31:24]), 32'hFF);

    // R10: command and offer together, offer must have no effect
    apply(1, 3'd4, 0, 1, 24'h777, 8'h00);
    apply(1, 3'd4, 0, 0, 0, 0);
    chk("R10", "slot after stalled offer", 32'(rsp_word[23:0]), 32'h0);

    // R5: IPI raised, then an external offer displaces it without a reject of source 2
    apply(1, 3'd3, 32'h40, 0, 0, 0);
    chk("R5", "irq after IPI request", 32'(irq_out), 32'd1);
    apply(0, 0, 0, 1, 24'h123, 8'h10);
    chk("R3", "no reject for displaced IPI", 32'(rej_valid), 32'd0);
    apply(1, 3'd0, 0, 0, 0, 0);
    chk("R4", "accepted word", rsp_word, 32'hFF000123);
    apply(1, 3'd1, 32'hFF000123, 0, 0, 0);
    apply(1, 3'd3, 32'hFF, 0, 0, 0);
    apply(1, 3'd0, 0, 0, 0, 0);
    apply(1, 3'd1, 32'hFF000002, 0, 0, 0);
    chk("R8", "no EOI forwarded for IPI number", 32'(eoi_valid), 32'd0);

    // Sweep over current priority, two offered priorities and an IPI request
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          apply(1, 3'd2, 32'(pv(i)), 0, 0, 0);
          apply(0, 0, 0, 1, 24'h100 + 24'(a), pv(a));
          apply(0, 0, 0, 1, 24'h200 + 24'(b), pv(b));
          apply(1, 3'd4, 0, 0, 0, 0);
          apply(1, 3'd3, 32'(pv((a + b) % 8)), 0, 0, 0);
          apply(1, 3'd2, 32'(pv((a * 3 + i) % 8)), 0, 0, 0);
          apply(1, 3'd0, 0, 0, 0, 0);
          apply(1, 3'd1, {pv(b), last_word[23:0]}, 0, 0, 0);
          apply(1, 3'd3, 32'hFF, 0, 0, 0);
          apply(1, 3'd0, 0, 0, 0, 0);
          apply(1, 3'd1, {8'hFF, last_word[23:0]}, 0, 0, 0);
        end
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule